// File: doc/BRIEF.md
# Operand Memory Access Phase Scheduler

The block sits beside the decode stage of a processor whose clock is split into two alternating half-phases. H1 is the first phase and H3 is the second. An instruction word comes in with an address-map verdict for each of its memory operands, which says internal or external. The block works out which operands touch data memory. It then raises one-cycle strobes, each with an address, so that every access lands in the phase that its kind and location demand.

Internal loads happen in the H1 of the execute pair and internal stores in the H3. External accesses always start on an H3. An external load also gets a completion strobe on the H1 that follows. When a three-operand instruction has both sources outside, the two external reads are issued one after the other. The block holds off the next instruction until the second read has started.

Each clock cycle of the block is one half-phase. The phase input says which half-phase the current cycle is. An instruction is taken at the end of an H3 cycle.

Top module: `operand_phase_sched`

## Requirements
- R1: Bits 31..29 of the instruction select the format. 000 and 010 select the two-operand format and 001 selects the three-operand format. Any other value makes a no-access instruction, even when bits 28 and 27 are set.
- R2: In the two-operand format, bit 28 set marks a memory operand, and bit 27 then selects a store (1) or a load (0). The operand address is bits 15..0. `map_int_i[0]` high means that address is internal.
- R3: In the three-operand format, bit 28 marks src1 as memory and bit 27 marks src2 as memory. The src1 address is bits 15..8 and the src2 address is bits 7..0, both zero-extended to 16 bits. `map_int_i[0]` and `map_int_i[1]` give their locations. This format never stores.
- R4: For an instruction accepted in cycle N, each internal load pulses `int_rd_o[0]` (src1 or the two-operand operand) or `int_rd_o[1]` (src2) in cycle N+1, which is an H1. The address sits in the low or high half of `int_rd_addr_o`.
- R5: An internal store pulses `int_wr_o` with `int_wr_addr_o` in cycle N+2, which is an H3.
- R6: The first external access pulses `ext_start_o` with `ext_addr_o` in cycle N+2, which is an H3. `ext_wr_o` is 1 for a store and 0 for a load. A store never produces a completion strobe.
- R7: An external load that starts in cycle M pulses `ext_rd_done_o` with the same address in cycle M+1, which is an H1.
- R8: When both three-operand sources are external, src1 starts in cycle N+2 and src2 starts in cycle N+4. Each is followed by its own completion strobe.
- R9: An instruction that is register-only or of no-access format produces no strobe at all.
- R10: An instruction is accepted only in a cycle where `instr_valid_i`, `ready_o` and `ph_h3_i` are all high. `ready_o` is low in cycles N+2 and N+3 of a dual-external instruction and high again in cycle N+4. A valid word in an H1 cycle is ignored.
- R11: While reset is asserted, all strobes are low and `ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one cycle per half-phase |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ph_h3_i | input | 1 | 1 in H3 cycles, 0 in H1 cycles |
| instr_valid_i | input | 1 | Instruction word present |
| instr_i | input | 32 | Instruction word |
| map_int_i | input | 2 | Per-operand internal-memory hit (bit 0: src1 or two-operand operand, bit 1: src2) |
| ready_o | output | 1 | Scheduler can take an instruction this cycle |
| int_rd_o | output | 2 | Internal load strobes, one per source slot |
| int_rd_addr_o | output | 32 | Internal load addresses, slot 1 in bits 31..16 |
| int_wr_o | output | 1 | Internal store strobe |
| int_wr_addr_o | output | 16 | Internal store address |
| ext_start_o | output | 1 | External access start strobe |
| ext_wr_o | output | 1 | Direction of the external access (1 store) |
| ext_addr_o | output | 16 | External access address |
| ext_rd_done_o | output | 1 | External load completion strobe |
| ext_rd_done_addr_o | output | 16 | Address of the completing external load |

## Verification
In every cycle, the assertions check the phase of each strobe: loads and completions only in H1, stores and starts only in H3. They also check that no two starts come back to back and that a store start is never followed by a completion. Only the bench scenarios can show the rest. That covers whether a given format and location mix gives exactly one strobe per memory operand, in the right cycle and with the right address. It also covers the serial order of a dual-external read, the stall on `ready_o`, and the silence of register-only, no-access-format and H1-presented words.

// File: rtl/opsched_pkg.sv
package opsched_pkg;
  localparam int INSTR_W = 32;
  localparam int AW      = 16;
  localparam int SRC_W   = 8;
  localparam int SLOTS   = 2;

  typedef enum logic [1:0] {FMT_NONE, FMT_TWO, FMT_THREE} fmt_t;
  typedef enum logic [2:0] {ST_IDLE, ST_E1, ST_E3, ST_W1, ST_B3} step_t;

  typedef struct packed {
    logic [SLOTS-1:0]         rd_int;
    logic [SLOTS-1:0][AW-1:0] rd_addr;
    logic                     wr_int;
    logic [AW-1:0]            wr_addr;
    logic                     ext_a_v;
    logic                     ext_a_wr;
    logic [AW-1:0]            ext_a_addr;
    logic                     ext_b_v;
    logic [AW-1:0]            ext_b_addr;
  } acc_plan_t;

  function automatic fmt_t fmt_of(input logic [2:0] code);
    case (code)
      3'b000, 3'b010: return FMT_TWO;
      3'b001:         return FMT_THREE;
      default:        return FMT_NONE;
    endcase
  endfunction

  function automatic acc_plan_t plan_of(input logic [2:0] code, input logic [1:0] mode,
                                        input logic [AW-1:0] fld, input logic [SLOTS-1:0] hit);
    acc_plan_t p;
    fmt_t f;
    logic two, three, m0, m1, st, e0, e1;
    logic [AW-1:0] a0, a1;
    f     = fmt_of(code);
    two   = (f == FMT_TWO);
    three = (f == FMT_THREE);
    m0    = (two | three) & mode[1];
    m1    = three & mode[0];
    st    = two & mode[0];
    a0    = two ? fld : AW'(fld[2*SRC_W-1:SRC_W]);
    a1    = AW'(fld[SRC_W-1:0]);
    e0    = m0 & ~hit[0];
    e1    = m1 & ~hit[1];
    p.rd_int     = {m1 & hit[1], m0 & hit[0] & ~st};
    p.rd_addr[0] = a0;
    p.rd_addr[1] = a1;
    p.wr_int     = m0 & hit[0] & st;
    p.wr_addr    = a0;
    p.ext_a_v    = e0 | e1;
    p.ext_a_wr   = e0 & st;
    p.ext_a_addr = e0 ? a0 : a1;
    p.ext_b_v    = e0 & e1;
    p.ext_b_addr = a1;
    return p;
  endfunction
endpackage

// File: rtl/opsched_decode.sv
module opsched_decode
  import opsched_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [SLOTS-1:0]   hit_i,
  output acc_plan_t          plan_o
);
  logic [2:0]    code;
  logic [1:0]    mode;
  logic [AW-1:0] fld;
  logic [10:0]   unused_dst_op;

  assign code          = instr_i[31:29];
  assign mode          = instr_i[28:27];
  assign fld           = instr_i[AW-1:0];
  assign unused_dst_op = instr_i[26:16];
  assign plan_o        = plan_of(code, mode, fld, hit_i);
endmodule

// File: rtl/opsched_sequencer.sv
module opsched_sequencer
  import opsched_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ph_h3_i,
  input  logic                  instr_valid_i,
  input  acc_plan_t             plan_i,
  output logic                  ready_o,
  output logic [SLOTS-1:0]      int_rd_o,
  output logic [SLOTS*AW-1:0]   int_rd_addr_o,
  output logic                  int_wr_o,
  output logic [AW-1:0]         int_wr_addr_o,
  output logic                  ext_start_o,
  output logic                  ext_wr_o,
  output logic [AW-1:0]         ext_addr_o
);
  step_t     step, step_nx;
  acc_plan_t cur;
  logic      take;

  assign ready_o = (step == ST_IDLE) | (step == ST_B3) | ((step == ST_E3) & ~cur.ext_b_v);
  assign take    = instr_valid_i & ph_h3_i & ready_o;

  always_comb begin
    step_nx = step;
    case (step)
      ST_IDLE: step_nx = take ? ST_E1 : ST_IDLE;
      ST_E1:   step_nx = ST_E3;
      ST_E3:   step_nx = take ? ST_E1 : (cur.ext_b_v ? ST_W1 : ST_IDLE);
      ST_W1:   step_nx = ST_B3;
      ST_B3:   step_nx = take ? ST_E1 : ST_IDLE;
      default: step_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step <= ST_IDLE;
      cur  <= '0;
    end else begin
      step <= step_nx;
      if (take) cur <= plan_i;
    end
  end

  assign int_rd_o      = (step == ST_E1) ? cur.rd_int : '0;
  assign int_rd_addr_o = cur.rd_addr;
  assign int_wr_o      = (step == ST_E3) & cur.wr_int;
  assign int_wr_addr_o = cur.wr_addr;
  assign ext_start_o   = ((step == ST_E3) & cur.ext_a_v) | (step == ST_B3);
  assign ext_wr_o      = (step == ST_E3) & cur.ext_a_wr;
  assign ext_addr_o    = (step == ST_B3) ? cur.ext_b_addr : cur.ext_a_addr;

  AST_INT_RD_IN_H1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_rd_o != '0) |-> !ph_h3_i); // R4
  AST_INT_WR_IN_H3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_wr_o |-> ph_h3_i); // R5
  AST_EXT_START_IN_H3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_start_o |-> ph_h3_i); // R6
endmodule

// File: rtl/opsched_ext_tracker.sv
module opsched_ext_tracker
  import opsched_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ph_h3_i,
  input  logic          ext_start_i,
  input  logic          ext_wr_i,
  input  logic [AW-1:0] ext_addr_i,
  output logic          done_o,
  output logic [AW-1:0] done_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      done_addr_o <= '0;
    end else begin
      done_o <= ext_start_i & ~ext_wr_i;
      if (ext_start_i) done_addr_o <= ext_addr_i;
    end
  end

  AST_DONE_IN_H1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ph_h3_i); // R7
endmodule

// File: rtl/operand_phase_sched.sv
module operand_phase_sched
  import opsched_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ph_h3_i,
  input  logic                instr_valid_i,
  input  logic [31:0]         instr_i,
  input  logic [1:0]          map_int_i,
  output logic                ready_o,
  output logic [1:0]          int_rd_o,
  output logic [31:0]         int_rd_addr_o,
  output logic                int_wr_o,
  output logic [15:0]         int_wr_addr_o,
  output logic                ext_start_o,
  output logic                ext_wr_o,
  output logic [15:0]         ext_addr_o,
  output logic                ext_rd_done_o,
  output logic [15:0]         ext_rd_done_addr_o
);
  acc_plan_t plan;

  opsched_decode u_decode (
    .instr_i (instr_i),
    .hit_i   (map_int_i),
    .plan_o  (plan)
  );

  opsched_sequencer u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ph_h3_i       (ph_h3_i),
    .instr_valid_i (instr_valid_i),
    .plan_i        (plan),
    .ready_o       (ready_o),
    .int_rd_o      (int_rd_o),
    .int_rd_addr_o (int_rd_addr_o),
    .int_wr_o      (int_wr_o),
    .int_wr_addr_o (int_wr_addr_o),
    .ext_start_o   (ext_start_o),
    .ext_wr_o      (ext_wr_o),
    .ext_addr_o    (ext_addr_o)
  );

  opsched_ext_tracker u_trk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ph_h3_i     (ph_h3_i),
    .ext_start_i (ext_start_o),
    .ext_wr_i    (ext_wr_o),
    .ext_addr_i  (ext_addr_o),
    .done_o      (ext_rd_done_o),
    .done_addr_o (ext_rd_done_addr_o)
  );

  AST_STORE_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_start_o && ext_wr_o) |=> !ext_rd_done_o); // R6
  AST_STARTS_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_start_o |=> !ext_start_o); // R8
endmodule

// File: tb/operand_phase_sched_tb_top.sv
`timescale 1ns/1ps
module operand_phase_sched_tb_top;
  localparam int K_RD0 = 0, K_RD1 = 1, K_WR = 2, K_XR = 3, K_XW = 4, K_DN = 5;

  logic clk = 1'b0, rst_n = 1'b0, ph = 1'b0, vld = 1'b0;
  logic [31:0] ins = '0;
  logic [1:0]  hit = '0;
  logic        rdy, int_wr, ext_start, ext_wr, done;
  logic [1:0]  int_rd;
  logic [31:0] int_rd_addr;
  logic [15:0] int_wr_addr, ext_addr, done_addr;
  int cyc = 0, nchk = 0, nfail = 0;

  typedef struct { int cyc; int kind; logic [15:0] addr; string tag; } exp_t;
  exp_t q[$];

  operand_phase_sched dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ph_h3_i(ph), .instr_valid_i(vld), .instr_i(ins),
    .map_int_i(hit), .ready_o(rdy), .int_rd_o(int_rd), .int_rd_addr_o(int_rd_addr),
    .int_wr_o(int_wr), .int_wr_addr_o(int_wr_addr), .ext_start_o(ext_start),
    .ext_wr_o(ext_wr), .ext_addr_o(ext_addr), .ext_rd_done_o(done),
    .ext_rd_done_addr_o(done_addr)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) ph <= rst_n ? ~ph : 1'b0;

  function automatic string ktag(int k);
    case (k)
      K_RD0, K_RD1: return "R4";
      K_WR:         return "R5";
      K_XR, K_XW:   return "R6";
      default:      return "R7";
    endcase
  endfunction

  task automatic push(int c, int k, logic [15:0] a, string t);
    exp_t e;
    e.cyc = c; e.kind = k; e.addr = a; e.tag = t;
    q.push_back(e);
  endtask

  // expected strobes computed from the requirements
  task automatic model(logic [31:0] w, logic [1:0] h, int n);
    logic two, three, m0, m1, st, e0, e1;
    logic [15:0] a0, a1;
    string ft;
    int t1;
    two   = (w[31:29] == 3'b000) || (w[31:29] == 3'b010);
    three = (w[31:29] == 3'b001);
    ft    = two ? "R1 R2" : "R1 R3";
    m0 = (two || three) && w[28];
    m1 = three && w[27];
    st = two && w[27];
    a0 = two ? w[15:0] : {8'h00, w[15:8]};
    a1 = {8'h00, w[7:0]};
    e0 = m0 && !h[0];
    e1 = m1 && !h[1];
    if (m0 && h[0] && !st) push(n + 1, K_RD0, a0, {ft, " R4"});
    if (m1 && h[1])        push(n + 1, K_RD1, a1, {ft, " R4"});
    if (m0 && h[0] && st)  push(n + 2, K_WR, a0, {ft, " R5"});
    if (e0) begin
      push(n + 2, st ? K_XW : K_XR, a0, {ft, " R6"});
      if (!st) push(n + 3, K_DN, a0, {ft, " R7"});
    end
    if (e1) begin
      t1 = e0 ? n + 4 : n + 2;
      push(t1, K_XR, a1, e0 ? "R8" : {ft, " R6"});
      push(t1 + 1, K_DN, a1, e0 ? "R8" : {ft, " R7"});
    end
  endtask

  task automatic observe(int k, logic on, logic [15:0] a);
    int idx;
    if (!on) return;
    idx = -1;
    for (int i = 0; i < q.size(); i++)
      if (idx < 0 && q[i].cyc == cyc && q[i].kind == k) idx = i;
    nchk++;
    if (idx < 0) begin
      nfail++;
      $display("FAIL %s cycle %0d: strobe kind %0d addr %h, expected none", ktag(k), cyc, k, a);
    end else begin
      if (q[idx].addr !== a) begin
        nfail++;
        $display("FAIL %s cycle %0d kind %0d: addr %h, expected %h", q[idx].tag, cyc, k, a, q[idx].addr);
      end
      q.delete(idx);
    end
  endtask

  // monitor: pops expected items as the design produces strobes
  always @(negedge clk) begin
    if (rst_n) begin
      observe(K_RD0, int_rd[0], int_rd_addr[15:0]);
      observe(K_RD1, int_rd[1], int_rd_addr[31:16]);
      observe(K_WR, int_wr, int_wr_addr);
      observe(ext_wr ? K_XW : K_XR, ext_start, ext_addr);
      observe(K_DN, done, done_addr);
      for (int i = q.size() - 1; i >= 0; i--)
        if (q[i].cyc <= cyc) begin
          nchk++; nfail++;
          $display("FAIL %s cycle %0d: missing strobe kind %0d, got none, expected addr %h",
                   q[i].tag, cyc, q[i].kind, q[i].addr);
          q.delete(i);
        end
    end
  end

  task automatic issue(logic [31:0] w, logic [1:0] h, output int n);
    do begin @(posedge clk); #1; end while (!(ph && rdy));
    ins = w; hit = h; vld = 1'b1; n = cyc;
    model(w, h, n);
    @(posedge clk); #1;
    vld = 1'b0; ins = '0; hit = '0;
  endtask

  task automatic quiet(int ncy, string tag);
    for (int i = 0; i < ncy; i++) begin
      @(negedge clk);
      nchk++;
      if (int_rd != 2'b00 || int_wr || ext_start || done) begin
        nfail++;
        $display("FAIL %s: strobes rd=%b wr=%b st=%b dn=%b, expected all 0", tag,
                 int_rd, int_wr, ext_start, done);
      end
    end
  endtask

  task automatic chk_rdy(logic exp, string tag);
    nchk++;
    if (rdy !== exp) begin
      nfail++;
      $display("FAIL %s: ready_o=%b, expected %b", tag, rdy, exp);
    end
  endtask

  function automatic logic [31:0] mk2(logic [2:0] f, logic m, logic s, logic [15:0] a);
    return {f, m, s, 11'h5A3, a};
  endfunction
  function automatic logic [31:0] mk3(logic m1, logic m2, logic [7:0] s1, logic [7:0] s2);
    return {3'b001, m1, m2, 11'h2C7, s1, s2};
  endfunction

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    nchk++;   // R11 reset state
    if (int_rd != 2'b00 || int_wr || ext_start || done || !rdy) begin
      nfail++;
      $display("FAIL R11: rd=%b wr=%b st=%b dn=%b rdy=%b, expected 0 0 0 0 1",
               int_rd, int_wr, ext_start, done, rdy);
    end
    @(posedge clk); #1; rst_n = 1'b1;

    issue(mk2(3'b000, 1, 0, 16'h1234), 2'b01, n);   // R2 internal load
    issue(mk2(3'b010, 1, 1, 16'hBEEF), 2'b01, n);   // R2 internal store
    issue(mk2(3'b000, 1, 0, 16'h4321), 2'b00, n);   // R2 external load
    issue(mk2(3'b010, 1, 1, 16'h8001), 2'b00, n);   // R2 external store
    issue(mk3(1, 0, 8'h3C, 8'h11), 2'b01, n);       // R3 src1 internal
    issue(mk3(0, 1, 8'h22, 8'hC5), 2'b00, n);       // R3 src2 external
    issue(mk3(1, 1, 8'hA1, 8'hB2), 2'b11, n);       // R3 both internal
    issue(mk3(1, 1, 8'h0F, 8'hF0), 2'b10, n);       // src1 ext, src2 int
    issue(mk3(1, 1, 8'h77, 8'h88), 2'b01, n);       // src1 int, src2 ext
    // R8 / R10: both sources external, stall on ready
    issue(mk3(1, 1, 8'h5D, 8'hE6), 2'b00, n);
    @(posedge clk); #1; chk_rdy(1'b0, "R10 cycle N+2");
    @(posedge clk); #1; chk_rdy(1'b0, "R10 cycle N+3");
    @(posedge clk); #1; chk_rdy(1'b1, "R10 cycle N+4");
    // back to back: completion overlaps next load phase
    issue(mk2(3'b000, 1, 0, 16'h0F0F), 2'b00, n);
    issue(mk2(3'b000, 1, 0, 16'h7070), 2'b01, n);
    repeat (4) @(posedge clk);
    // R9 register-only and no-access formats
    issue(mk2(3'b000, 0, 1, 16'hFFFF), 2'b00, n); quiet(4, "R9 reg-only two-op");
    issue(mk3(0, 0, 8'h12, 8'h34), 2'b00, n);     quiet(4, "R9 reg-only three-op");
    issue(mk2(3'b100, 1, 1, 16'h1111), 2'b00, n); quiet(4, "R1 R9 format 100");
    issue(mk2(3'b111, 1, 0, 16'h2222), 2'b11, n); quiet(4, "R1 R9 format 111");
    // R10: valid word in an H1 cycle is ignored
    do begin @(posedge clk); #1; end while (!(!ph && rdy));
    ins = mk2(3'b000, 1, 0, 16'h3333); hit = 2'b01; vld = 1'b1;
    @(posedge clk); #1; vld = 1'b0; ins = '0; hit = '0;
    quiet(5, "R10 H1 word ignored");

    repeat (8) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule